// File: doc/BRIEF.md
# Serial Converter Frame Sequencer

This block is the host side of a link to a serial analog-to-digital converter that is framed by an active-low select. It produces the select and the serial clock from the system clock and shifts in the converter's 16-bit frame. It then drops the four leading bits and hands the 12-bit result to a valid/ready output. The block also reports whether those four leading bits were all zero.

The converter's power state is controlled only through the length of each frame. A 2-bit command chooses one of three actions:

- a full-length read;
- a short burst that releases select early, which puts the converter to sleep;
- a full-length dummy frame that wakes the converter and whose data is thrown away.

Between frames, the block holds select high for a programmable quiet time. After a wake frame, it also waits out a programmable power-up time before it accepts the next command. The clock divider, the frame lengths and all waiting times are parameters.

Top module: `adc_frame_sequencer`

## Requirements
- R1: After synchronous reset, `csn_o` and `sclk_o` are high, while `busy`, `smp_valid` and `smp_err` are low. `cmd_ready` is high.
- R2: When no frame is running, `sclk_o` rests high. Within a frame, every low phase and every high phase of `sclk_o` lasts exactly `HALF_CYC` clocks. Select falls `HALF_CYC` clocks before the first falling clock edge.
- R3: Command codes 0 and 3 are reads. A read holds `csn_o` low for exactly 16 falling clock edges. Select rises `HALF_CYC` clocks after the last rising edge.
- R4: `sdata_i` is sampled in the clock cycle in which `sclk_o` falls, and frame bits arrive MSB first. At the end of a read frame, the last 12 bits appear on `smp_data` and `smp_valid` rises in the same cycle as `csn_o`.
- R5: `smp_err` is 1 exactly when any of the four bits received before the data bits is 1.
- R6: Command code 1 runs a sleep burst of `SLEEP_EDGES` falling edges (8 by default; legal range 2 to 9). A sleep burst produces no sample.
- R7: Command code 2 runs a 16-edge wake frame. Its data is discarded, so no sample is produced.
- R8: After a wake command is accepted, `busy` stays high and no new frame starts until at least `PWRUP_CYC`+1 clock edges have passed since acceptance.
- R9: `busy` goes high on the edge that accepts a command. It stays high while select is low and for `QUIET_CYC` clocks after select rises, so select is high for at least `QUIET_CYC`+1 clocks between frames.
- R10: `cmd_ready` is low while `busy` is high or a sample is still pending. `smp_valid`, `smp_data` and `smp_err` hold steady until `smp_ready` is seen high.
- R11: A command offered while `cmd_ready` is low is ignored: select stays high and no frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_op | input | 2 | Command code: 0/3 read, 1 sleep, 2 wake |
| cmd_ready | output | 1 | Command can be accepted |
| sclk_o | output | 1 | Serial clock to the converter |
| csn_o | output | 1 | Active-low frame select |
| sdata_i | input | 1 | Serial data from the converter |
| smp_valid | output | 1 | Sample available |
| smp_data | output | DATA_BITS | Captured sample, natural binary |
| smp_err | output | 1 | Leading bits were not all zero |
| smp_ready | input | 1 | Consumer takes the sample |
| busy | output | 1 | Frame or mandatory wait in progress |

## Verification
The hardest case to reach is the power-up wait that outlasts the frame and quiet time. This only shows up when a wake frame is followed at once by a queued read. The bench therefore runs a short half period with a long power-up count, and keeps the read request asserted from the moment the wake command is taken. A second hard case is a command offered while a finished sample is still held back by a low `smp_ready`. The bench holds off the consumer and offers a command in that window.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_SLEEP = 2'd1,
    OP_WAKE  = 2'd2,
    OP_READ2 = 2'd3
  } seq_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_LOW,
    ST_HIGH,
    ST_QUIET
  } seq_state_e;

endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // R2: once running, the count steps down by one each clock
  a_r2_count_down: assert property (@(posedge clk) disable iff (rst)
    (!zero && !load) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/adc_seq_shifter.sv
module adc_seq_shifter #(
  parameter int FRAME_BITS = 16,
  parameter int DATA_BITS  = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 shift_en,
  input  logic                 sdata,
  output logic [DATA_BITS-1:0] data,
  output logic                 lead_nz
);

  localparam int LEAD_BITS = FRAME_BITS - DATA_BITS;

  logic [FRAME_BITS-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst)           sr <= '0;
    else if (shift_en) sr <= {sr[FRAME_BITS-2:0], sdata};
  end

  assign data = sr[DATA_BITS-1:0];

  generate
    if (LEAD_BITS > 0) begin : g_lead
      assign lead_nz = |sr[FRAME_BITS-1:DATA_BITS];
    end else begin : g_nolead
      assign lead_nz = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/adc_seq_outbuf.sv
module adc_seq_outbuf #(
  parameter int DATA_BITS = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic [DATA_BITS-1:0] ld_data,
  input  logic                 ld_err,
  input  logic                 ready,
  output logic                 valid,
  output logic [DATA_BITS-1:0] data,
  output logic                 err
);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      data  <= '0;
      err   <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= ld_data;
      err   <= ld_err;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  // R10: a pending sample is held unchanged until it is taken
  a_r10_hold_sample: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready) |=> (valid && $stable(data) && $stable(err)));

endmodule

// File: rtl/adc_frame_sequencer.sv
module adc_frame_sequencer
  import adc_seq_pkg::*;
#(
  parameter int HALF_CYC    = 7,
  parameter int QUIET_CYC   = 4,
  parameter int PWRUP_CYC   = 125,
  parameter int FRAME_BITS  = 16,
  parameter int DATA_BITS   = 12,
  parameter int SLEEP_EDGES = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_valid,
  input  logic [1:0]           cmd_op,
  output logic                 cmd_ready,
  output logic                 sclk_o,
  output logic                 csn_o,
  input  logic                 sdata_i,
  output logic                 smp_valid,
  output logic [DATA_BITS-1:0] smp_data,
  output logic                 smp_err,
  input  logic                 smp_ready,
  output logic                 busy
);

  localparam int TMAX = (HALF_CYC > QUIET_CYC) ? HALF_CYC : QUIET_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int PW   = $clog2(PWRUP_CYC + 1);
  localparam int EW   = $clog2(FRAME_BITS + 1);

  seq_state_e    st;
  seq_op_e       op_q;
  logic [EW-1:0] edges;
  logic [EW-1:0] last_edge;
  logic          ph_load, ph_zero, wk_load, wk_zero;
  logic [TW-1:0] ph_val;
  logic          accept, fall_now, frame_end, is_read;
  logic          csn_q, sclk_q, busy_q;
  logic [DATA_BITS-1:0] cap_data;
  logic          cap_nz;

  assign cmd_ready = (st == ST_IDLE) && !smp_valid;
  assign accept    = cmd_valid && cmd_ready;
  assign last_edge = (op_q == OP_SLEEP) ? EW'(SLEEP_EDGES) : EW'(FRAME_BITS);
  assign is_read   = (op_q == OP_READ) || (op_q == OP_READ2);
  assign fall_now  = ph_zero && ((st == ST_LEAD) ||
                     ((st == ST_HIGH) && (edges != last_edge)));
  assign frame_end = ph_zero && (st == ST_HIGH) && (edges == last_edge);

  always_comb begin
    ph_load = 1'b0;
    ph_val  = TW'(HALF_CYC - 1);
    if (accept) begin
      ph_load = 1'b1;
    end else if (ph_zero && (st == ST_LEAD || st == ST_LOW || st == ST_HIGH)) begin
      ph_load = 1'b1;
      if (frame_end) ph_val = TW'(QUIET_CYC - 1);
    end
  end

  assign wk_load = accept && (cmd_op == OP_WAKE);

  adc_seq_timer #(.W(TW)) u_phase (
    .clk(clk), .rst(rst), .load(ph_load), .load_val(ph_val), .zero(ph_zero)
  );

  adc_seq_timer #(.W(PW)) u_wake (
    .clk(clk), .rst(rst), .load(wk_load), .load_val(PW'(PWRUP_CYC)), .zero(wk_zero)
  );

  adc_seq_shifter #(.FRAME_BITS(FRAME_BITS), .DATA_BITS(DATA_BITS)) u_shift (
    .clk(clk), .rst(rst), .shift_en(fall_now), .sdata(sdata_i),
    .data(cap_data), .lead_nz(cap_nz)
  );

  adc_seq_outbuf #(.DATA_BITS(DATA_BITS)) u_out (
    .clk(clk), .rst(rst), .load(frame_end && is_read), .ld_data(cap_data),
    .ld_err(cap_nz), .ready(smp_ready), .valid(smp_valid), .data(smp_data),
    .err(smp_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      op_q   <= OP_READ;
      edges  <= '0;
      csn_q  <= 1'b1;
      sclk_q <= 1'b1;
      busy_q <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (accept) begin
          op_q   <= seq_op_e'(cmd_op);
          csn_q  <= 1'b0;
          busy_q <= 1'b1;
          edges  <= '0;
          st     <= ST_LEAD;
        end
        ST_LEAD: if (ph_zero) begin
          sclk_q <= 1'b0;
          edges  <= edges + 1'b1;
          st     <= ST_LOW;
        end
        ST_LOW: if (ph_zero) begin
          sclk_q <= 1'b1;
          st     <= ST_HIGH;
        end
        ST_HIGH: if (ph_zero) begin
          if (edges == last_edge) begin
            csn_q <= 1'b1;
            st    <= ST_QUIET;
          end else begin
            sclk_q <= 1'b0;
            edges  <= edges + 1'b1;
            st     <= ST_LOW;
          end
        end
        ST_QUIET: if (ph_zero && wk_zero) begin
          busy_q <= 1'b0;
          st     <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign csn_o  = csn_q;
  assign sclk_o = sclk_q;
  assign busy   = busy_q;

  // R2: clock rests high whenever select is released
  a_r2_idle_high: assert property (@(posedge clk) disable iff (rst)
    csn_o |-> sclk_o);
  // R2: select falls while the clock is still high
  a_r2_lead_high: assert property (@(posedge clk) disable iff (rst)
    $fell(csn_o) |-> sclk_o);
  // R9: busy covers the whole time select is low
  a_r9_busy_framed: assert property (@(posedge clk) disable iff (rst)
    !csn_o |-> busy);
  // R10: no command is offered acceptance while busy
  a_r10_no_ready_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> !cmd_ready);
  // R3: edge count never passes the frame length
  a_r3_edge_bound: assert property (@(posedge clk) disable iff (rst)
    edges <= EW'(FRAME_BITS));
  // R6: a sleep burst ends after exactly its configured edge count
  a_r6_sleep_len: assert property (@(posedge clk) disable iff (rst)
    (st == ST_QUIET && op_q == OP_SLEEP) |-> (edges == EW'(SLEEP_EDGES)));

endmodule

// File: tb/adc_frame_sequencer_test.sv
module adc_frame_sequencer_test;
  localparam int H = 2, Q = 3, P = 100, FB = 16, DB = 12, SE = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic cmd_ready, sclk_o, csn_o, sdata_i, smp_valid, smp_err, busy;
  logic [DB-1:0] smp_data;
  logic smp_ready = 1'b1;

  adc_frame_sequencer #(.HALF_CYC(H), .QUIET_CYC(Q), .PWRUP_CYC(P),
    .FRAME_BITS(FB), .DATA_BITS(DB), .SLEEP_EDGES(SE)) uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_ready(cmd_ready), .sclk_o(sclk_o), .csn_o(csn_o), .sdata_i(sdata_i),
    .smp_valid(smp_valid), .smp_data(smp_data), .smp_err(smp_err),
    .smp_ready(smp_ready), .busy(busy));

  // converter model: bit 0 driven at select fall, next bit on each clock fall
  logic [15:0] conv_q[$];
  logic [15:0] cur_word = 16'h0;
  int bit_idx = 0;
  always @(negedge csn_o) begin
    if (conv_q.size() > 0) cur_word = conv_q.pop_front();
    else cur_word = 16'h0;
    bit_idx = 0;
  end
  always @(negedge sclk_o) if (!csn_o) bit_idx++;
  assign sdata_i = (!csn_o && bit_idx < 16) ? cur_word[15 - bit_idx] : 1'b0;

  int nchk = 0, nfail = 0;
  bit done = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // reference model state
  bit active = 0, exp_vld = 0, exp_e = 0, pend_cmd = 0, pend_pop = 0;
  int t = 0, mop = 0, pend_op = 0, e_end = 0, b_end = 0;
  logic [DB-1:0] exp_d = '0;
  bit x_csn, x_sclk;
  string lbl_csn, lbl_busy;

  always @(negedge clk) begin
    if (rst) begin
      active = 0; exp_vld = 0; pend_cmd = 0; pend_pop = 0;
    end else if (!done) begin
      if (pend_cmd) begin active = 1; t = 0; mop = pend_op; end
      else if (active) t++;
      if (pend_pop) exp_vld = 0;
      e_end = (2 * ((mop == 1) ? SE : FB) + 1) * H;
      b_end = e_end + Q;
      if (mop == 2 && P + 1 > b_end) b_end = P + 1;
      if (active && t >= b_end) active = 0;
      if (active && (mop == 0 || mop == 3) && t == e_end) begin
        exp_vld = 1;
        exp_d = cur_word[11:0];
        exp_e = |cur_word[15:12];
      end
      x_csn  = !(active && t < e_end);
      x_sclk = (!active || t < H || t >= e_end) ? 1'b1 : (((t - H) / H) % 2 == 1);
      lbl_csn  = !active ? "R11" : (mop == 1) ? "R6" : (mop == 2) ? "R7" : "R3";
      lbl_busy = (mop == 2 && t >= e_end + Q) ? "R8" : "R9";
      chk(lbl_csn, "csn_o", csn_o, x_csn);
      chk("R2", "sclk_o", sclk_o, x_sclk);
      chk(lbl_busy, "busy", busy, active);
      chk("R10", "cmd_ready", cmd_ready, !active && !exp_vld);
      chk("R4", "smp_valid", smp_valid, exp_vld);
      if (exp_vld) begin
        chk("R4", "smp_data", smp_data, exp_d);
        chk("R5", "smp_err", smp_err, exp_e);
      end
      pend_cmd = cmd_valid && !active && !exp_vld;
      pend_op  = cmd_op;
      pend_pop = exp_vld && smp_ready;
    end
  end

  task automatic issue(input int op, input logic [15:0] w);
    conv_q.push_back(w);
    @(posedge clk); #1;
    cmd_valid = 1'b1; cmd_op = op[1:0];
    do @(negedge clk); while (!cmd_ready);
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "csn_o", csn_o, 1); chk("R1", "sclk_o", sclk_o, 1);
    chk("R1", "busy", busy, 0); chk("R1", "smp_valid", smp_valid, 0);
    chk("R1", "smp_err", smp_err, 0); chk("R1", "cmd_ready", cmd_ready, 1);
    issue(0, 16'h0ABC); wait_idle();          // R3 R4 plain read
    issue(0, 16'h0FFF); wait_idle();          // R9 back-to-back quiet time
    issue(3, 16'h0000); wait_idle();          // R3 alternate read code
    smp_ready = 1'b0;
    issue(0, 16'h8123); wait_idle();          // R5 leading bit set
    repeat (4) @(posedge clk);
    #1 cmd_valid = 1'b1; cmd_op = 2'd2;       // R11 offered while sample pending
    repeat (5) @(posedge clk);
    #1 cmd_valid = 1'b0;
    repeat (3) @(posedge clk);
    #1 smp_ready = 1'b1;                      // R10 release held sample
    repeat (3) @(posedge clk);
    issue(1, 16'hFFFF);                       // R6 sleep burst
    repeat (8) @(posedge clk);
    #1 cmd_valid = 1'b1; cmd_op = 2'd0;       // R11 offered while busy
    repeat (3) @(posedge clk);
    #1 cmd_valid = 1'b0;
    wait_idle();
    issue(2, 16'h1234);                       // R7 wake frame, discarded
    issue(0, 16'h0555); wait_idle();          // R8 read waits for power-up
    issue(0, 16'h7001); wait_idle();          // R5 error with data
    repeat (6) @(posedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL R9 watchdog actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule